// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 level-sensitive peripheral request lines and folds them into two processor-facing request outputs: a normal interrupt line and a fast interrupt line. Every source has an enable bit and a steering bit. The steering bit routes the source to one output or the other. Sources are grouped in banks of 32, and each bank has its own small register group on a plain read/write strobe bus. The bus uses byte offsets and 32-bit data.

A programmable table of priority slots lets software pick the order in which enabled normal-interrupt sources are reported. Each slot names one source and carries a valid bit. A lowest-index scan over this table drives a "winner" register, which software reads to learn which source to service first. A policy bit chooses what drives a wake output for an idle processor: any raw request, or only enabled requests.

The request lines pass through one register stage. The two request outputs and the wake output are registered once more. Reads are combinational and return zero whenever the read strobe is low.

Top module: `prioritized_intc`

## Requirements
- R1: After reset, all enable, steering, slot and control registers read zero. The irq_o, fiq_o and wake_o outputs are low, and the winner register (0x18) reads zero.
- R2: An enable bit of 1 lets its source through and 0 blocks it. The enable register is at 0x04 for bank 0 (sources 31:0) and at 0xA0 for bank 1 (sources 63:32). Bit n of a bank register is source 32·bank+n. The enable registers change only when written at their own offset.
- R3: A steering bit of 0 sends an enabled source to the normal line, and 1 sends it to the fast line. The steering register is at 0x08 for bank 0 and at 0xA4 for bank 1, and reads back what was written.
- R4: The raw view (0x10 / 0xAC) shows the request inputs one clock after they are sampled. The normal-pending view (0x00 / 0x9C) is raw AND enable AND NOT steering. The fast-pending view (0x0C / 0xA8) is raw AND enable AND steering. All three views are read-only, and writes to them have no effect.
- R5: The winner register at 0x18 has bit 31 as a valid flag and bits 30:16 as a source ID; all other bits are 0. It names the source of the lowest-index valid slot whose source is normal-pending. If no such slot exists, it reads zero, even while normal requests are pending.
- R6: Slot i is at 0x1C+4·i for i<32 and at 0xB0+4·(i−32) for i≥32. Bit 31 is the slot's valid flag and bits 5:0 hold the source ID. A slot reads back those fields, with all other bits at zero.
- R7: irq_o is high exactly one clock after some normal-pending bit is set.
- R8: fiq_o is high exactly one clock after some fast-pending bit is set.
- R9: The control register at 0x14 holds one bit (bit 0), and its other bits read 0. When it is 0, wake_o follows any raw request. When it is 1, wake_o follows only enabled raw requests. Either way, wake_o has one clock of latency.
- R10: Reads of offsets not listed above return zero, and writes to them change no register. bus_rdata is zero whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level request lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake request |

## Verification
A single request is first raised with its enable bit clear, then enabled, then steered to the fast line. This separates the raw, normal-pending and fast-pending views and both request outputs. A request in the upper bank confirms that the second register group decodes to the right source bits.

The priority table is loaded in reverse source order, and four requests are raised together: one steered to the fast line and three enabled normal ones. Requests are then removed from contention one at a time, by disabling a source and by invalidating slots. This shows that the winner follows slot order rather than source number, skips fast-steered sources, and drops to zero when no valid slot matches.

Wake is checked under both policy settings while a disabled request is present, since that is the only case in which the two settings differ.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int BANK_W        = 32;
   localparam int MAX_SRC       = 64;
   localparam int MAX_SLOTS     = 64;
   localparam int FLAG_BIT      = 31;
   localparam int WIN_ID_LSB    = 16;
   localparam int WIN_ID_W      = 15;

   localparam int OFS_NPEND     = 'h00;
   localparam int OFS_ENABLE    = 'h04;
   localparam int OFS_STEER     = 'h08;
   localparam int OFS_FPEND     = 'h0C;
   localparam int OFS_RAW       = 'h10;
   localparam int OFS_CTRL      = 'h14;
   localparam int OFS_WINNER    = 'h18;

   function automatic int bank_base(input int b);
      return (b == 0) ? 'h00 : 'h9C;
   endfunction

   function automatic int slot_offset(input int i);
      return (i < 32) ? ('h1C + 4 * i) : ('hB0 + 4 * (i - 32));
   endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int W = BANK_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  logic         en_we,
   input  logic         steer_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] raw_o,
   output logic [W-1:0] en_o,
   output logic [W-1:0] steer_o,
   output logic [W-1:0] npend_o,
   output logic [W-1:0] fpend_o
);
   logic [W-1:0] raw_q, en_q, steer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q   <= '0;
         en_q    <= '0;
         steer_q <= '0;
      end else begin
         raw_q <= src_i;
         if (en_we)    en_q    <= wdata;
         if (steer_we) steer_q <= wdata;
      end
   end

   assign raw_o   = raw_q;
   assign en_o    = en_q;
   assign steer_o = steer_q;
   assign npend_o = raw_q & en_q & ~steer_q;
   assign fpend_o = raw_q & en_q & steer_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int NUM_SRC   = 64,
   parameter int NUM_SLOTS = 64,
   parameter int ID_W      = $clog2(NUM_SRC)
) (
   input  logic [NUM_SLOTS-1:0]           slot_vld,
   input  logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id,
   input  logic [NUM_SRC-1:0]             npend,
   output logic                           hit_o,
   output logic [ID_W-1:0]                id_o
);
   always_comb begin
      hit_o = 1'b0;
      id_o  = '0;
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
         if (slot_vld[s] && npend[slot_id[s]]) begin
            hit_o = 1'b1;
            id_o  = slot_id[s];
         end
      end
   end
endmodule

// File: rtl/prioritized_intc.sv
module prioritized_intc
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int NUM_SLOTS = 64,
   parameter int ADDR_W    = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o,
   output logic               fiq_o,
   output logic               wake_o
);
   localparam int NUM_BANKS = NUM_SRC / BANK_W;
   localparam int ID_W      = $clog2(NUM_SRC);
   localparam int ID_PAD    = WIN_ID_W - ID_W;

   if (NUM_SRC % BANK_W != 0 || NUM_SRC < BANK_W || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must be 32 or 64");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be 1..64");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x12C");
   end

   logic [NUM_SRC-1:0] raw_all, en_all, steer_all, npend_all, fpend_all;
   logic [NUM_SLOTS-1:0]           slot_vld_q;
   logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id_q;
   logic                           ctrl_q;
   logic                           win_hit;
   logic [ID_W-1:0]                win_id;
   logic [31:0]                    rd_val;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      intc_bank #(.W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_i    (src_i[b*BANK_W +: BANK_W]),
         .en_we    (bus_wr && bus_addr == ADDR_W'(bank_base(b) + OFS_ENABLE)),
         .steer_we (bus_wr && bus_addr == ADDR_W'(bank_base(b) + OFS_STEER)),
         .wdata    (bus_wdata),
         .raw_o    (raw_all[b*BANK_W +: BANK_W]),
         .en_o     (en_all[b*BANK_W +: BANK_W]),
         .steer_o  (steer_all[b*BANK_W +: BANK_W]),
         .npend_o  (npend_all[b*BANK_W +: BANK_W]),
         .fpend_o  (fpend_all[b*BANK_W +: BANK_W])
      );
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_vld_q[s] <= 1'b0;
            slot_id_q[s]  <= '0;
         end else if (bus_wr && bus_addr == ADDR_W'(slot_offset(s))) begin
            slot_vld_q[s] <= bus_wdata[FLAG_BIT];
            slot_id_q[s]  <= bus_wdata[ID_W-1:0];
         end
      end
   end

   intc_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_prio (
      .slot_vld (slot_vld_q),
      .slot_id  (slot_id_q),
      .npend    (npend_all),
      .hit_o    (win_hit),
      .id_o     (win_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
         irq_o  <= 1'b0;
         fiq_o  <= 1'b0;
         wake_o <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) ctrl_q <= bus_wdata[0];
         irq_o  <= |npend_all;
         fiq_o  <= |fpend_all;
         wake_o <= ctrl_q ? |(raw_all & en_all) : |raw_all;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(bank_base(b) + OFS_NPEND)) rd_val = npend_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(bank_base(b) + OFS_ENABLE)) rd_val = en_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(bank_base(b) + OFS_STEER)) rd_val = steer_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(bank_base(b) + OFS_FPEND)) rd_val = fpend_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(bank_base(b) + OFS_RAW)) rd_val = raw_all[b*BANK_W +: BANK_W];
      end
      if (bus_addr == ADDR_W'(OFS_CTRL)) rd_val = {31'b0, ctrl_q};
      if (bus_addr == ADDR_W'(OFS_WINNER))
         rd_val = {win_hit, {ID_PAD{1'b0}}, win_id, 16'b0};
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (bus_addr == ADDR_W'(slot_offset(s)))
            rd_val = {slot_vld_q[s], {(31-ID_W){1'b0}}, slot_id_q[s]};
      end
   end

   assign bus_rdata = bus_rd ? rd_val : 32'b0;
endmodule

// File: rtl/prioritized_intc_chk.sv
module prioritized_intc_chk
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int ADDR_W  = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               irq_o,
   input logic               fiq_o,
   input logic               wake_o,
   input logic [NUM_SRC-1:0] raw_all,
   input logic [NUM_SRC-1:0] en_all,
   input logic [NUM_SRC-1:0] npend_all,
   input logic [NUM_SRC-1:0] fpend_all,
   input logic               win_hit
);
   localparam int NB = NUM_SRC / BANK_W;

   function automatic logic en_addr(input logic [ADDR_W-1:0] a);
      logic r = 1'b0;
      for (int b = 0; b < NB; b++)
         if (a == ADDR_W'(bank_base(b) + OFS_ENABLE)) r = 1'b1;
      return r;
   endfunction

   assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|npend_all));

   assert_fiq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == $past(|fpend_all));

   assert_win_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> (|npend_all));

   assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && en_addr(bus_addr)) |=> $stable(en_all));

   assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(|raw_all));
endmodule

bind prioritized_intc prioritized_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .wake_o    (wake_o),
   .raw_all   (raw_all),
   .en_all    (en_all),
   .npend_all (npend_all),
   .fpend_all (fpend_all),
   .win_hit   (win_hit)
);

// File: tb/prioritized_intc_tb_top.sv
module prioritized_intc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 64;
   localparam int AW   = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_i = '0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_o, fiq_o, wake_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prioritized_intc #(.NUM_SRC(NSRC), .NUM_SLOTS(64), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd('h04, v); check("R1 enable0", v, 0);
      rd('h08, v); check("R1 steer0", v, 0);
      rd('h14, v); check("R1 ctrl", v, 0);
      rd('h18, v); check("R1 winner", v, 0);
      rd('h1C, v); check("R1 slot0", v, 0);
      check("R1 irq_o", {31'b0, irq_o}, 0);
      check("R1 fiq_o", {31'b0, fiq_o}, 0);
      check("R1 wake_o", {31'b0, wake_o}, 0);
   endtask

   task automatic t_raw_wake();
      logic [31:0] v;
      @(negedge clk); src_i = NSRC'(1) << 5;
      settle();
      rd('h10, v); check("R4 raw0", v, 32'h20);
      rd('h00, v); check("R2 masked npend0", v, 0);
      check("R2 irq_o masked", {31'b0, irq_o}, 0);
      check("R9 wake any raw", {31'b0, wake_o}, 1);
      wr('h14, 32'hFFFF_FFFF);
      rd('h14, v); check("R9 ctrl readback", v, 1);
      settle();
      check("R9 wake enabled only", {31'b0, wake_o}, 0);
      wr('h10, 32'h0);
      rd('h10, v); check("R4 raw read-only", v, 32'h20);
   endtask

   task automatic t_enable_irq();
      logic [31:0] v;
      wr('h04, 32'h20);
      settle();
      rd('h00, v); check("R4 npend0", v, 32'h20);
      check("R7 irq_o", {31'b0, irq_o}, 1);
      check("R8 fiq_o idle", {31'b0, fiq_o}, 0);
      check("R9 wake enabled", {31'b0, wake_o}, 1);
   endtask

   task automatic t_fiq();
      logic [31:0] v;
      wr('h08, 32'h20);
      settle();
      rd('h08, v); check("R3 steer readback", v, 32'h20);
      rd('h00, v); check("R3 npend0 steered", v, 0);
      rd('h0C, v); check("R4 fpend0", v, 32'h20);
      check("R8 fiq_o", {31'b0, fiq_o}, 1);
      check("R7 irq_o off", {31'b0, irq_o}, 0);
   endtask

   task automatic t_bank1();
      logic [31:0] v;
      @(negedge clk); src_i = (NSRC'(1) << 5) | (NSRC'(1) << 40);
      wr('hA0, 32'h100);
      settle();
      rd('hAC, v); check("R4 raw1", v, 32'h100);
      rd('h9C, v); check("R4 npend1", v, 32'h100);
      rd('hA0, v); check("R2 enable1", v, 32'h100);
      check("R7 irq_o bank1", {31'b0, irq_o}, 1);
   endtask

   task automatic t_prio();
      logic [31:0] v;
      for (int i = 0; i < 64; i++) begin
         int a;
         a = (i < 32) ? ('h1C + 4 * i) : ('hB0 + 4 * (i - 32));
         wr(a, 32'h8000_0000 | (63 - i));
      end
      rd('h1C, v); check("R6 slot0", v, 32'h8000_003F);
      rd('hB0, v); check("R6 slot32", v, 32'h8000_001F);
      @(negedge clk);
      src_i = (NSRC'(1) << 3) | (NSRC'(1) << 5) | (NSRC'(1) << 40) | (NSRC'(1) << 50);
      wr('h04, 32'h28);
      wr('hA0, 32'h0004_0100);
      settle();
      rd('h18, v); check("R5 winner 50", v, 32'h8032_0000);
      wr('hA0, 32'h100);
      settle();
      rd('h18, v); check("R5 winner 40", v, 32'h8028_0000);
      wr('h78, 32'd40);
      rd('h78, v); check("R6 slot23 invalid", v, 32'd40);
      rd('h18, v); check("R5 winner 3", v, 32'h8003_0000);
      wr('h120, 32'd3);
      rd('h18, v); check("R5 no slot match", v, 0);
      settle();
      check("R7 irq_o without winner", {31'b0, irq_o}, 1);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr('h1F0, 32'hFFFF_FFFF);
      rd('h04, v); check("R10 enable0 untouched", v, 32'h28);
      rd('h1F0, v); check("R10 unmapped read", v, 0);
      rd('h130, v); check("R10 past last slot", v, 0);
      @(negedge clk); bus_addr = AW'('h04); bus_rd = 1'b0;
      #1 check("R10 rdata idle", bus_rdata, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_raw_wake();
      t_enable_irq();
      t_fiq();
      t_bank1();
      t_prio();
      t_unmapped();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule